// File: doc/BRIEF.md
# Double-Buffered Frame Swap Controller

This block arbitrates two banks of raster frame-buffer memory. At any time one bank feeds the video scan-out and the other takes new drawing. A frame command starts the exchange. In its swapping form the controller waits for the next vertical retrace strobe and then exchanges the two bank roles. After the exchange it sweeps the new render bank to zero, one word address per clock. Bit planes whose write-protect bit is set are left untouched.

The command handshake is a valid/ready pair plus a one-cycle done pulse. Done is raised only after both the exchange and the sweep are complete. A command flagged "no swap" skips the exchange and the sweep. An end-of-program command also skips both. Each of these two is acknowledged at once. The bank size (a square of `FB_DIM` pixels per side) and the plane count (2, 4, 6 or 8) are parameters. The drawing engine and the video serialiser sit outside the block.

Top module: `frame_swap_ctrl`

## Requirements
- R1: After reset, bank 0 is displayed (`disp_bank`=0), `cmd_ready`=1, `cmd_done`=0 and `clr_we`=0.
- R2: After a swapping begin-frame command (`cmd_op`=0, `cmd_noswap`=0) is accepted, the banks and the clear port stay idle until `vretrace` is sampled high while the command waits. A retrace strobe with no command waiting changes nothing.
- R3: The displayed bank toggles on the clock edge at which a waiting command samples `vretrace` high, and at no other time.
- R4: On the cycle after the swap, the clear sweep begins. It presents addresses 0 up to `FB_DIM*FB_DIM-1`, one per cycle in rising order, on `clr_addr`, with `clr_bank` equal to the new render bank (the bank not displayed).
- R5: `clr_plane_en` is the bitwise inverse of `wp_mask` as captured when the command was accepted. When every plane is protected, the sweep still takes its full length but `clr_we` stays 0.
- R6: `cmd_done` is high for exactly one cycle, namely the cycle after the last sweep address.
- R7: A begin-frame command with `cmd_noswap`=1 causes no swap and no clear writes, and `cmd_done` is high in the cycle after acceptance.
- R8: An end-of-program command (`cmd_op`=1) causes no swap and no clear writes, whatever `cmd_noswap` is, and `cmd_done` is high in the cycle after acceptance.
- R9: `cmd_ready` is low from the cycle after acceptance through the done cycle. A request presented meanwhile is held off and is accepted only once `cmd_ready` returns high.
- R10: `disp_sel` is one-hot with bit `disp_bank` set, and `rend_sel` is its bitwise inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 1 | 0 = begin frame, 1 = end of program |
| cmd_noswap | input | 1 | 1 = begin frame without swap or clear |
| cmd_ready | output | 1 | Controller can accept a command |
| cmd_done | output | 1 | One-cycle completion pulse |
| vretrace | input | 1 | Vertical retrace strobe |
| wp_mask | input | PLANES | Per-plane write protect, 1 = protected |
| disp_bank | output | 1 | Index of the displayed bank |
| disp_sel | output | 2 | One-hot display bank select |
| rend_sel | output | 2 | One-hot render bank select |
| clr_we | output | 1 | Clear write strobe |
| clr_bank | output | 1 | Bank written by the clear |
| clr_addr | output | ADDR_W | Clear word address |
| clr_plane_en | output | PLANES | Per-plane write enable; written data is zero |

## Verification
The bench drives swapping commands under several masks: none protected, a mixed pattern, and all planes protected. These runs separate a correct per-plane enable from one that ignores or misreads the mask, and from a write strobe that fires with nothing to write. No-swap and end-of-program commands, including an end command with the swap flag clear, show whether the swap and sweep are gated by both fields. Retrace strobes fall at fixed intervals unrelated to the commands, so some come while the controller is idle and some while a command waits; this exposes a swap taken outside the waiting state. A request held high through a busy command shows that it is held off and then accepted exactly once.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WAIT  = 2'd1,
      PH_CLEAR = 2'd2,
      PH_ACK   = 2'd3
   } fsc_phase_t;

   localparam logic OP_BEGIN = 1'b0;
   localparam logic OP_END   = 1'b1;

   function automatic bit plane_count_ok(input int n);
      return (n == 2) || (n == 4) || (n == 6) || (n == 8);
   endfunction

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/fsc_phase_ctrl.sv
module fsc_phase_ctrl
   import fsc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic       cmd_op,
   input  logic       cmd_noswap,
   input  logic       vretrace,
   input  logic       sweep_last,
   output fsc_phase_t phase,
   output logic       cmd_ready,
   output logic       cmd_done,
   output logic       accept,
   output logic       swap_now
);

   fsc_phase_t ph_q, ph_d;
   logic       skip_work;

   assign cmd_ready = (ph_q == PH_IDLE);
   assign cmd_done  = (ph_q == PH_ACK);
   assign accept    = cmd_valid && cmd_ready;
   assign swap_now  = (ph_q == PH_WAIT) && vretrace;
   assign skip_work = (cmd_op == OP_END) || cmd_noswap;
   assign phase     = ph_q;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE: begin
            if (accept) begin
               ph_d = skip_work ? PH_ACK : PH_WAIT;
            end
         end
         PH_WAIT: begin
            if (vretrace) ph_d = PH_CLEAR;
         end
         PH_CLEAR: begin
            if (sweep_last) ph_d = PH_ACK;
         end
         PH_ACK: ph_d = PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

endmodule

// File: rtl/fsc_clear_sweep.sv
module fsc_clear_sweep
   import fsc_pkg::*;
#(
   parameter int WORDS  = 1024 * 1024,
   parameter int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              active,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

   if (!is_pow2(WORDS)) begin : g_bad_words
      $error("fsc_clear_sweep: WORDS must be a power of two of at least 2");
   end

   logic              active_q;
   logic [ADDR_W-1:0] addr_q;

   assign active = active_q;
   assign addr   = addr_q;
   assign last   = active_q && (addr_q == LAST_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         addr_q   <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         addr_q   <= '0;
      end else if (active_q) begin
         if (last) begin
            active_q <= 1'b0;
            addr_q   <= '0;
         end else begin
            addr_q <= addr_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/fsc_bank_state.sv
module fsc_bank_state
   import fsc_pkg::*;
#(
   parameter int PLANES = 8,
   parameter int BANKS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swap,
   input  logic              capture,
   input  logic [PLANES-1:0] mask_in,
   output logic              disp_bank,
   output logic [BANKS-1:0]  disp_sel,
   output logic [BANKS-1:0]  rend_sel,
   output logic [PLANES-1:0] plane_en,
   output logic              any_en
);

   if (BANKS != 2) begin : g_bad_banks
      $error("fsc_bank_state: exactly two banks are supported");
   end

   logic              bank_q;
   logic [PLANES-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= 1'b0;
         mask_q <= '1;
      end else begin
         if (swap)    bank_q <= ~bank_q;
         if (capture) mask_q <= mask_in;
      end
   end

   assign disp_bank = bank_q;

   for (genvar b = 0; b < BANKS; b++) begin : g_sel
      assign disp_sel[b] = (bank_q == b[0]);
      assign rend_sel[b] = (bank_q != b[0]);
   end

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      assign plane_en[p] = ~mask_q[p];
   end

   assign any_en = |plane_en;

endmodule

// File: rtl/frame_swap_ctrl.sv
module frame_swap_ctrl
   import fsc_pkg::*;
#(
   parameter int FB_DIM = 1024,
   parameter int PLANES = 8,
   parameter int WORDS  = FB_DIM * FB_DIM,
   parameter int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_op,
   input  logic              cmd_noswap,
   output logic              cmd_ready,
   output logic              cmd_done,
   input  logic              vretrace,
   input  logic [PLANES-1:0] wp_mask,
   output logic              disp_bank,
   output logic [1:0]        disp_sel,
   output logic [1:0]        rend_sel,
   output logic              clr_we,
   output logic              clr_bank,
   output logic [ADDR_W-1:0] clr_addr,
   output logic [PLANES-1:0] clr_plane_en
);

   if (!plane_count_ok(PLANES)) begin : g_bad_planes
      $error("frame_swap_ctrl: PLANES must be 2, 4, 6 or 8");
   end
   if (!is_pow2(FB_DIM)) begin : g_bad_dim
      $error("frame_swap_ctrl: FB_DIM must be a power of two");
   end

   fsc_phase_t phase;
   logic       accept;
   logic       swap_now;
   logic       sweep_active;
   logic       sweep_last;
   logic       any_en;

   fsc_phase_ctrl u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_noswap (cmd_noswap),
      .vretrace   (vretrace),
      .sweep_last (sweep_last),
      .phase      (phase),
      .cmd_ready  (cmd_ready),
      .cmd_done   (cmd_done),
      .accept     (accept),
      .swap_now   (swap_now)
   );

   fsc_clear_sweep #(
      .WORDS  (WORDS),
      .ADDR_W (ADDR_W)
   ) u_sweep (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (swap_now),
      .active (sweep_active),
      .addr   (clr_addr),
      .last   (sweep_last)
   );

   fsc_bank_state #(
      .PLANES (PLANES),
      .BANKS  (2)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .swap      (swap_now),
      .capture   (accept),
      .mask_in   (wp_mask),
      .disp_bank (disp_bank),
      .disp_sel  (disp_sel),
      .rend_sel  (rend_sel),
      .plane_en  (clr_plane_en),
      .any_en    (any_en)
   );

   assign clr_we   = sweep_active && any_en && (phase == PH_CLEAR);
   assign clr_bank = ~disp_bank;

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
   parameter int PLANES = 8,
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              cmd_done,
   input logic              vretrace,
   input logic              disp_bank,
   input logic [1:0]        disp_sel,
   input logic [1:0]        rend_sel,
   input logic              clr_we,
   input logic [ADDR_W-1:0] clr_addr,
   input logic [PLANES-1:0] clr_plane_en,
   input logic              sweep_active
);

   p_swap_at_retrace_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_bank != $past(disp_bank)) |-> $past(vretrace));

   p_no_swap_in_sweep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_active |=> $stable(disp_bank));

   p_sweep_from_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sweep_active) |-> (clr_addr == '0));

   p_sweep_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sweep_active && $past(sweep_active)) |-> (clr_addr == ADDR_W'($past(clr_addr) + 1'b1)));

   p_write_needs_plane_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |-> (sweep_active && (clr_plane_en != '0)));

   p_done_after_sweep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sweep_active) |-> cmd_done);

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);

   p_busy_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> !cmd_ready);

   p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(disp_sel) && (rend_sel == ~disp_sel) && disp_sel[disp_bank]);

endmodule

bind frame_swap_ctrl fsc_checker #(
   .PLANES (PLANES),
   .ADDR_W (ADDR_W)
) u_fsc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_ready    (cmd_ready),
   .cmd_done     (cmd_done),
   .vretrace     (vretrace),
   .disp_bank    (disp_bank),
   .disp_sel     (disp_sel),
   .rend_sel     (rend_sel),
   .clr_we       (clr_we),
   .clr_addr     (clr_addr),
   .clr_plane_en (clr_plane_en),
   .sweep_active (sweep_active)
);

// File: tb/frame_swap_ctrl_bench.sv
`timescale 1ns/1ps
module frame_swap_ctrl_bench;

   localparam int FB_DIM = 4;
   localparam int PLANES = 4;
   localparam int WORDS  = FB_DIM * FB_DIM;
   localparam int ADDR_W = $clog2(WORDS);
   localparam int VR_PERIOD = 23;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_op = 1'b0;
   logic              cmd_noswap = 1'b0;
   logic              cmd_ready, cmd_done;
   logic              vretrace = 1'b0;
   logic [PLANES-1:0] wp_mask = '0;
   logic              disp_bank;
   logic [1:0]        disp_sel, rend_sel;
   logic              clr_we, clr_bank;
   logic [ADDR_W-1:0] clr_addr;
   logic [PLANES-1:0] clr_plane_en;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int we_cnt = 0;

   frame_swap_ctrl #(.FB_DIM(FB_DIM), .PLANES(PLANES)) u_frame_swap_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_noswap(cmd_noswap), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
      .vretrace(vretrace), .wp_mask(wp_mask), .disp_bank(disp_bank),
      .disp_sel(disp_sel), .rend_sel(rend_sel), .clr_we(clr_we),
      .clr_bank(clr_bank), .clr_addr(clr_addr), .clr_plane_en(clr_plane_en)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // retrace strobe, independent of commands
   always @(negedge clk) begin
      cyc <= cyc + 1;
      vretrace <= ((cyc % VR_PERIOD) == 7);
      if (clr_we) we_cnt <= we_cnt + 1;
   end

   // behavioural reference model
   bit                m_waiting, m_clearing, m_ack, m_bank;
   int                m_pos;
   logic [PLANES-1:0] m_mask;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_waiting = 0; m_clearing = 0; m_ack = 0; m_bank = 0; m_pos = 0; m_mask = '1;
      end else if (m_ack) begin
         m_ack = 0;
      end else if (m_waiting) begin
         if (vretrace) begin
            m_bank = !m_bank; m_waiting = 0; m_clearing = 1; m_pos = 0;
         end
      end else if (m_clearing) begin
         if (m_pos == WORDS - 1) begin
            m_clearing = 0; m_ack = 1; m_pos = 0;
         end else begin
            m_pos++;
         end
      end else if (cmd_valid) begin
         m_mask = wp_mask;
         if (cmd_op || cmd_noswap) m_ack = 1;
         else m_waiting = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit idle;
         bit exp_we;
         idle   = !(m_waiting || m_clearing || m_ack);
         exp_we = m_clearing && (m_mask != '1);
         chk(cmd_ready == idle, "R9 cmd_ready", int'(cmd_ready), int'(idle));
         chk(cmd_done == m_ack, "R6 cmd_done", int'(cmd_done), int'(m_ack));
         chk(disp_bank == m_bank, "R3 disp_bank", int'(disp_bank), int'(m_bank));
         chk(clr_we == exp_we, "R5 clr_we", int'(clr_we), int'(exp_we));
         chk(disp_sel == (m_bank ? 2'b10 : 2'b01), "R10 disp_sel", int'(disp_sel), m_bank ? 2 : 1);
         chk(rend_sel == ~disp_sel, "R10 rend_sel", int'(rend_sel), int'(~disp_sel));
         if (m_clearing) begin
            chk(clr_addr == ADDR_W'(m_pos), "R4 clr_addr", int'(clr_addr), m_pos);
            chk(clr_bank == !m_bank, "R4 clr_bank", int'(clr_bank), int'(!m_bank));
         end
         if (exp_we)
            chk(clr_plane_en == ~m_mask, "R5 clr_plane_en", int'(clr_plane_en), int'(~m_mask));
      end
   end

   // returns at the negedge right after the accepting edge
   task automatic send(input bit op, input bit noswap, input logic [PLANES-1:0] mask);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_noswap = noswap; wp_mask = mask;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      we_cnt = 0;
   endtask

   task automatic wait_done();
      while (!cmd_done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      bit b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(disp_bank == 1'b0, "R1 disp_bank", int'(disp_bank), 0);
      chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
      chk(cmd_done == 1'b0 && clr_we == 1'b0, "R1 done/we", int'({cmd_done, clr_we}), 0);
      repeat (30) @(negedge clk);     // idle retrace strobes pass
      chk(disp_bank == 1'b0, "R2 idle retrace ignored", int'(disp_bank), 0);

      // R2/R3/R4 swapping frame, nothing protected
      send(1'b0, 1'b0, 4'b0000);
      chk(disp_bank == 1'b0 && !clr_we, "R2 wait before retrace", int'(disp_bank), 0);
      wait_done();
      chk(disp_bank == 1'b1, "R3 swapped", int'(disp_bank), 1);
      chk(we_cnt == WORDS, "R4 sweep length", we_cnt, WORDS);

      // R5 mixed mask
      send(1'b0, 1'b0, 4'b0101);
      wait_done();
      chk(disp_bank == 1'b0, "R3 swapped back", int'(disp_bank), 0);
      chk(we_cnt == WORDS, "R5 mixed mask writes", we_cnt, WORDS);

      // R5 all protected
      send(1'b0, 1'b0, 4'b1111);
      wait_done();
      chk(we_cnt == 0, "R5 all protected no writes", we_cnt, 0);
      chk(disp_bank == 1'b1, "R5 swap still done", int'(disp_bank), 1);

      // R7 no-swap frame
      b0 = disp_bank;
      send(1'b0, 1'b1, 4'b0000);
      chk(cmd_done == 1'b1, "R7 immediate done", int'(cmd_done), 1);
      wait_done();
      chk(disp_bank == b0 && we_cnt == 0, "R7 no swap no clear", int'(disp_bank), int'(b0));

      // R8 end-of-program, swap flag clear
      send(1'b1, 1'b0, 4'b0000);
      chk(cmd_done == 1'b1, "R8 immediate done", int'(cmd_done), 1);
      wait_done();
      repeat (30) @(negedge clk);
      chk(disp_bank == b0 && we_cnt == 0, "R8 no swap no clear", int'(disp_bank), int'(b0));

      // R9 request held off while busy, then accepted once
      send(1'b0, 1'b0, 4'b0011);
      chk(cmd_ready == 1'b0, "R9 busy after accept", int'(cmd_ready), 0);
      send(1'b0, 1'b1, 4'b0000);      // waits for ready, held off
      chk(cmd_done == 1'b1, "R9 held request completes", int'(cmd_done), 1);
      wait_done();
      repeat (5) @(negedge clk);
      chk(cmd_ready == 1'b1 && disp_bank == !b0, "R9 accepted exactly once", int'(disp_bank), int'(!b0));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule